// File: doc/BRIEF.md
# Block Security Map Register File

This block is the programming side of a memory security filter. The protected memory is split into equal blocks. One bit per block, packed into 32-bit lookup words, says whether that block belongs to the secure world (0) or the non-secure world (1). Software reaches the lookup words through a single window register. A pointer register selects the word behind the window, and the pointer can step forward by itself after each full-word window access, wrapping to zero after the last word. The whole table, the error-response enable and the lockdown state go out as plain signals to a separate filter block. That filter block decides pass or block per transaction and raises a one-cycle `fault_event` when it blocks one.

The register bus is a single-cycle request port. It always accepts, so there is no back-pressure. A read returns its data one cycle later, marked by `rsp_valid`. Each request carries a word address, byte strobes and a secure attribute. Strobes of `1111` make a word access. One strobe set, or a pair on lanes 0-1 or 2-3, makes a byte or halfword access. Only secure requesters may touch the configuration. Non-secure requesters see the identification bytes and nothing else. A lockdown bit freezes the control register, the lookup words and the interrupt enable until the next reset.

Top module: `secmap_regfile`

Register offsets (byte address = `req_waddr` × 4): control 0x00, word count 0x10, granule 0x14, pointer 0x18, window 0x1C, status 0x20, clear 0x24, enable 0x28, fault address 0x2C, fault attributes 0x30, set 0x34, identification 0xFD0–0xFFC.

## Requirements
- R1: After reset the control register reads 0x100, the pointer reads 0, status reads 0, enable reads 1, every lookup word is 0 and `irq` is 0.
- R2: The control register keeps only bit 4 (error response, driven on `err_resp_en`), bit 8 (auto-step) and bit 31 (lockdown, driven on `lock_active`). All other bits read as 0 whatever is written.
- R3: A non-secure read of any offset below 0xFD0 returns 0. A non-secure write there changes nothing, and a non-secure window read does not step the pointer.
- R4: While bit 31 of control is 1, writes to control, the window and enable are ignored, and an ignored window write does not step the pointer. Pointer, set and clear writes still act. Only reset clears the lock.
- R5: A word access to the window reads or writes the lookup word at the pointer. With control bit 8 set, the pointer then steps by one modulo the word count. Byte and halfword window accesses, and any access with bit 8 clear, leave the pointer unchanged.
- R6: A pointer write stores the written value modulo the word count. Offset 0x10 reads the word count minus 1. Offset 0x14 reads log2(block bytes) − 5.
- R7: Sub-word writes to control, pointer and window replace only the strobed bytes of the current value. Sub-word writes to any other register treat the unstrobed bytes as zero.
- R8: Writing 1 in bit 0 of offset 0x34 sets status. Writing 1 in bit 0 of 0x24 clears it. A `fault_event` also sets status and wins over a clear in the same cycle. `irq` equals status AND enable, and reads of 0x24 and 0x34 return 0.
- R9: The twelve identification words from 0xFD0 upward read 0x04, 0x00, 0x00, 0x00, 0x60, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in their low byte, for secure and non-secure requesters alike.
- R10: `lut_bits[32*k+31:32*k]` always equals lookup word k.
- R11: Every read request gives `rsp_valid` high in the next cycle with the data. A write gives `rsp_valid` low. Offsets not listed read 0.
- R12: Offsets 0x2C and 0x30 read back `fault_addr` and `fault_attr` as sampled in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_waddr | input | 10 | Word address (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes |
| req_secure | input | 1 | Requester is secure |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| fault_event | input | 1 | Filter blocked a transaction this cycle |
| fault_addr | input | 32 | Captured fault address from the filter |
| fault_attr | input | 32 | Captured fault attributes from the filter |
| lut_bits | output | 32×LUT_WORDS | All lookup words, word 0 in the low bits |
| err_resp_en | output | 1 | Filter should answer blocked accesses with an error |
| lock_active | output | 1 | Lockdown is in force |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check several properties on every cycle. The lock bit never falls before reset. The pointer always stays below the word count. Sub-word window accesses never move the pointer. While locked, the lookup words and the enable stay put. A fault event is always followed by status set, and a lone clear by status low. Non-secure reads below the identification space always return zero, and every read is answered in the next cycle. Other behaviour can only be shown by the bench's scenarios: the exact merge of each byte lane, the modulo results for out-of-range pointer values, the wrap order of auto-step, the identification values and the reset values.

// File: rtl/secmap_pkg.sv
package secmap_pkg;

  localparam logic [11:0] OFF_CTRL    = 12'h000;
  localparam logic [11:0] OFF_WCOUNT  = 12'h010;
  localparam logic [11:0] OFF_GRAN    = 12'h014;
  localparam logic [11:0] OFF_PTR     = 12'h018;
  localparam logic [11:0] OFF_WIN     = 12'h01C;
  localparam logic [11:0] OFF_STAT    = 12'h020;
  localparam logic [11:0] OFF_CLR     = 12'h024;
  localparam logic [11:0] OFF_EN      = 12'h028;
  localparam logic [11:0] OFF_INFA    = 12'h02C;
  localparam logic [11:0] OFF_INFB    = 12'h030;
  localparam logic [11:0] OFF_SET     = 12'h034;
  localparam logic [11:0] OFF_ID_BASE = 12'hFD0;

  localparam int CTL_ERR  = 4;
  localparam int CTL_STEP = 8;
  localparam int CTL_LOCK = 31;

  localparam logic [31:0] CTL_KEEP = 32'h8000_0110;
  localparam logic [31:0] CTL_INIT = 32'h0000_0100;

  typedef struct packed {
    logic ctrl;
    logic wcount;
    logic gran;
    logic ptr;
    logic win;
    logic stat;
    logic clr;
    logic en;
    logic infa;
    logic infb;
    logic set;
    logic id;
  } sel_t;

  function automatic logic [31:0] lane_mask(input logic [3:0] s);
    return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                             input logic [31:0] nw,
                                             input logic [31:0] m);
    return (cur & ~m) | (nw & m);
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    case (k)
      4'd0:    return 8'h04;
      4'd4:    return 8'h60;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h1B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/secmap_decode.sv
module secmap_decode
  import secmap_pkg::*;
(
  input  logic       valid,
  input  logic       write,
  input  logic       secure,
  input  logic [9:0] waddr,
  input  logic [3:0] strb,
  output sel_t       sel,
  output logic       wr,
  output logic       rd,
  output logic       full,
  output logic [3:0] id_k
);

  logic [11:0] off;
  logic        open_ok;

  always_comb begin
    off     = {waddr, 2'b00};
    open_ok = secure || (off >= OFF_ID_BASE);
    wr      = valid && write && open_ok;
    rd      = valid && !write && open_ok;
    full    = &strb;
    id_k    = waddr[3:0] - 4'd4;
    sel        = '0;
    sel.ctrl   = (off == OFF_CTRL);
    sel.wcount = (off == OFF_WCOUNT);
    sel.gran   = (off == OFF_GRAN);
    sel.ptr    = (off == OFF_PTR);
    sel.win    = (off == OFF_WIN);
    sel.stat   = (off == OFF_STAT);
    sel.clr    = (off == OFF_CLR);
    sel.en     = (off == OFF_EN);
    sel.infa   = (off == OFF_INFA);
    sel.infb   = (off == OFF_INFB);
    sel.set    = (off == OFF_SET);
    sel.id     = (off >= OFF_ID_BASE);
  end

endmodule

// File: rtl/secmap_ctrl.sv
module secmap_ctrl
  import secmap_pkg::*;
#(
  parameter int LUT_WORDS = 4,
  parameter int IW        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic          full,
  input  logic          sel_ctrl,
  input  logic          sel_ptr,
  input  logic          sel_win,
  input  logic [31:0]   wmask,
  input  logic [31:0]   wdata,
  output logic [31:0]   ctrl_q,
  output logic [IW-1:0] idx_q
);

  logic          locked;
  logic          advance;
  logic [31:0]   ptr_merged;
  logic [IW-1:0] ptr_next;

  always_comb begin
    locked     = ctrl_q[CTL_LOCK];
    advance    = sel_win && full && ctrl_q[CTL_STEP] && (rd || (wr && !locked));
    ptr_merged = lane_merge(32'(idx_q), wdata, wmask);
    ptr_next   = IW'(ptr_merged % 32'(LUT_WORDS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTL_INIT;
    end else if (wr && sel_ctrl && !locked) begin
      ctrl_q <= lane_merge(ctrl_q, wdata, wmask) & CTL_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (wr && sel_ptr) begin
      idx_q <= ptr_next;
    end else if (advance) begin
      idx_q <= (idx_q == IW'(LUT_WORDS - 1)) ? '0 : idx_q + IW'(1);
    end
  end

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CTL_LOCK] |=> ctrl_q[CTL_LOCK]);

  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx_q) < 32'(LUT_WORDS));

  assert_subword_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_win && !full && (wr || rd)) |=> $stable(idx_q));

endmodule

// File: rtl/secmap_lut.sv
module secmap_lut #(
  parameter int LUT_WORDS = 4,
  parameter int IW        = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   sel_win,
  input  logic                   locked,
  input  logic [IW-1:0]          idx,
  input  logic [31:0]            wmask,
  input  logic [31:0]            wdata,
  output logic [LUT_WORDS*32-1:0] lut_flat,
  output logic [31:0]            cur_word
);

  logic [31:0] words [LUT_WORDS];
  logic        we;

  assign we       = wr && sel_win && !locked;
  assign cur_word = words[idx];

  always_ff @(posedge clk) begin
    for (int k = 0; k < LUT_WORDS; k++) begin
      if (!rst_n) begin
        words[k] <= '0;
      end else if (we && (idx == IW'(k))) begin
        words[k] <= (words[k] & ~wmask) | (wdata & wmask);
      end
    end
  end

  for (genvar g = 0; g < LUT_WORDS; g++) begin : g_flat
    assign lut_flat[g*32 +: 32] = words[g];
  end

  assert_locked_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(lut_flat));

endmodule

// File: rtl/secmap_irq.sv
module secmap_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic locked,
  input  logic sel_clr,
  input  logic sel_en,
  input  logic sel_set,
  input  logic bit0,
  input  logic violation,
  output logic stat_q,
  output logic en_q,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (violation || (wr && sel_set && bit0)) begin
      stat_q <= 1'b1;
    end else if (wr && sel_clr && bit0) begin
      stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b1;
    end else if (wr && sel_en && !locked) begin
      en_q <= bit0;
    end
  end

  assign irq = stat_q & en_q;

  assert_fault_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> stat_q);

  assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_clr && bit0 && !violation) |=> !stat_q);

  assert_locked_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(en_q));

endmodule

// File: rtl/secmap_regfile.sv
module secmap_regfile
  import secmap_pkg::*;
#(
  parameter int LUT_WORDS = 4,
  parameter int BLK_BYTES = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [9:0]              req_waddr,
  input  logic [31:0]             req_wdata,
  input  logic [3:0]              req_strb,
  input  logic                    req_secure,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  input  logic                    fault_event,
  input  logic [31:0]             fault_addr,
  input  logic [31:0]             fault_attr,
  output logic [LUT_WORDS*32-1:0] lut_bits,
  output logic                    err_resp_en,
  output logic                    lock_active,
  output logic                    irq
);

  localparam int IW = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1;
  localparam logic [31:0] GRAN_VAL = 32'($clog2(BLK_BYTES) - 5);
  localparam logic [31:0] WMAX_VAL = 32'(LUT_WORDS - 1);

  sel_t          sel;
  logic          wr, rd, full;
  logic [3:0]    id_k;
  logic [31:0]   wmask;
  logic [31:0]   ctrl_q;
  logic [IW-1:0] idx_q;
  logic [31:0]   cur_word;
  logic          stat_q, en_q;
  logic [31:0]   rd_mux;

  assign wmask = lane_mask(req_strb);

  secmap_decode u_decode (
    .valid  (req_valid),
    .write  (req_write),
    .secure (req_secure),
    .waddr  (req_waddr),
    .strb   (req_strb),
    .sel    (sel),
    .wr     (wr),
    .rd     (rd),
    .full   (full),
    .id_k   (id_k)
  );

  secmap_ctrl #(.LUT_WORDS(LUT_WORDS), .IW(IW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .rd       (rd),
    .full     (full),
    .sel_ctrl (sel.ctrl),
    .sel_ptr  (sel.ptr),
    .sel_win  (sel.win),
    .wmask    (wmask),
    .wdata    (req_wdata),
    .ctrl_q   (ctrl_q),
    .idx_q    (idx_q)
  );

  secmap_lut #(.LUT_WORDS(LUT_WORDS), .IW(IW)) u_lut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .sel_win  (sel.win),
    .locked   (ctrl_q[CTL_LOCK]),
    .idx      (idx_q),
    .wmask    (wmask),
    .wdata    (req_wdata),
    .lut_flat (lut_bits),
    .cur_word (cur_word)
  );

  secmap_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr),
    .locked    (ctrl_q[CTL_LOCK]),
    .sel_clr   (sel.clr),
    .sel_en    (sel.en),
    .sel_set   (sel.set),
    .bit0      (req_wdata[0] & req_strb[0]),
    .violation (fault_event),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .irq       (irq)
  );

  assign err_resp_en = ctrl_q[CTL_ERR];
  assign lock_active = ctrl_q[CTL_LOCK];

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel.ctrl:   rd_mux = ctrl_q;
      sel.wcount: rd_mux = WMAX_VAL;
      sel.gran:   rd_mux = GRAN_VAL;
      sel.ptr:    rd_mux = 32'(idx_q);
      sel.win:    rd_mux = cur_word;
      sel.stat:   rd_mux = {31'd0, stat_q};
      sel.en:     rd_mux = {31'd0, en_q};
      sel.infa:   rd_mux = fault_addr;
      sel.infb:   rd_mux = fault_attr;
      sel.id:     rd_mux = {24'd0, id_byte(id_k)};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end

  assert_ns_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_secure && (req_waddr < 10'h3F4)) |=> (rsp_rdata == 32'd0));

  assert_read_answered_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_write_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);

endmodule

// File: tb/tb_secmap_regfile.sv
`timescale 1ns/1ps
module tb_secmap_regfile;

  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b1;
  logic [9:0]    req_waddr = '0;
  logic [31:0]   req_wdata = '0;
  logic [3:0]    req_strb = 4'hF;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          fault_event = 1'b0;
  logic [31:0]   fault_addr = 32'h1234_5678;
  logic [31:0]   fault_attr = 32'h0003_00AB;
  logic [NW*32-1:0] lut_bits;
  logic          err_resp_en, lock_active, irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] m [NW];
  logic [31:0] r;
  logic        v;

  always #2.5 clk = ~clk;

  secmap_regfile #(.LUT_WORDS(NW), .BLK_BYTES(128)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_waddr(req_waddr), .req_wdata(req_wdata), .req_strb(req_strb),
    .req_secure(req_secure), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .fault_event(fault_event), .fault_addr(fault_addr), .fault_attr(fault_attr),
    .lut_bits(lut_bits), .err_resp_en(err_resp_en), .lock_active(lock_active),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic acc(input bit w, input logic [11:0] off, input logic [31:0] d,
                     input logic [3:0] s, input bit sec);
    req_valid = 1'b1; req_write = w; req_waddr = off[11:2];
    req_wdata = d; req_strb = s; req_secure = sec;
    @(negedge clk);
    r = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b1;
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d, input logic [3:0] s);
    acc(1'b1, off, d, s, 1'b1);
  endtask

  task automatic rdc(input string tag, input logic [11:0] off, input bit sec,
                     input logic [31:0] exp);
    acc(1'b0, off, 32'd0, 4'hF, sec);
    chk(tag, {96'd0, r}, {96'd0, exp});
  endtask

  function automatic logic [31:0] bm(input logic [31:0] cur, input logic [31:0] d,
                                     input logic [3:0] s);
    logic [31:0] o = cur;
    for (int b = 0; b < 4; b++) if (s[b]) o[b*8 +: 8] = d[b*8 +: 8];
    return o;
  endfunction

  function automatic logic [127:0] flat();
    return {m[3], m[2], m[1], m[0]};
  endfunction

  function automatic logic [7:0] idv(input int k);
    logic [7:0] t [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h60, 8'hB8,
                          8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NW; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {127'd0, irq}, 128'd0);
    chk("R10 lut after reset", lut_bits, 128'd0);
    rdc("R1 ctrl", 12'h000, 1, 32'h100);
    rdc("R1 ptr", 12'h018, 1, 0);
    rdc("R1 stat", 12'h020, 1, 0);
    rdc("R1 en", 12'h028, 1, 1);
    for (int i = 0; i < NW; i++) rdc("R1 word", 12'h01C, 1, 0);
    rdc("R5 wrap after reads", 12'h018, 1, 0);

    // R12 info read-back
    rdc("R12 info addr", 12'h02C, 1, 32'h1234_5678);
    rdc("R12 info attr", 12'h030, 1, 32'h0003_00AB);

    // R9 identification, both worlds
    for (int k = 0; k < 12; k++) begin
      rdc("R9 id secure", 12'hFD0 + 12'(4*k), 1, {24'd0, idv(k)});
      rdc("R9 id nonsecure", 12'hFD0 + 12'(4*k), 0, {24'd0, idv(k)});
    end

    // R6 geometry and pointer modulo
    rdc("R6 word count", 12'h010, 1, NW - 1);
    rdc("R6 granule", 12'h014, 1, 2);
    for (int x = 0; x < 10; x++) begin
      wr(12'h018, 32'(x), 4'hF);
      rdc("R6 ptr modulo", 12'h018, 1, 32'(x % NW));
    end

    // R5 auto-step writes with wrap
    wr(12'h018, 0, 4'hF);
    for (int i = 0; i < 6; i++) begin
      wr(12'h01C, 32'h1111_1111 * 32'(i + 1), 4'hF);
      m[i % NW] = 32'h1111_1111 * 32'(i + 1);
    end
    rdc("R5 ptr after 6 writes", 12'h018, 1, 32'(6 % NW));
    chk("R10 lut export", lut_bits, flat());
    for (int j = 0; j < NW; j++) rdc("R5 read order", 12'h01C, 1, m[(2 + j) % NW]);

    // R5 sub-word access does not step
    wr(12'h018, 1, 4'hF);
    wr(12'h01C, 32'h00AB_0000, 4'b0100);
    m[1] = bm(m[1], 32'h00AB_0000, 4'b0100);
    rdc("R5 byte no step", 12'h018, 1, 1);
    acc(1'b0, 12'h01C, 0, 4'b0011, 1'b1);
    rdc("R5 half read no step", 12'h018, 1, 1);

    // R7 lane merges on window (auto-step off)
    wr(12'h000, 32'h0, 4'hF);
    for (int b = 0; b < 4; b++) begin
      wr(12'h01C, {4{8'h5A + 8'(b)}}, 4'(1 << b));
      m[1] = bm(m[1], {4{8'h5A + 8'(b)}}, 4'(1 << b));
      rdc("R7 window lane merge", 12'h01C, 1, m[1]);
    end
    wr(12'h01C, 32'hDEAD_BEEF, 4'hF);
    m[1] = 32'hDEAD_BEEF;
    rdc("R5 step off keeps ptr", 12'h018, 1, 1);
    chk("R10 lut export 2", lut_bits, flat());

    // R7 pointer merge
    wr(12'h018, 3, 4'hF);
    wr(12'h018, 0, 4'b1100);
    rdc("R7 ptr upper half merge", 12'h018, 1, 3);
    wr(12'h018, 32'h0000_0006, 4'b0001);
    rdc("R7 ptr byte merge mod", 12'h018, 1, 2);

    // R2 control bits, R7 control merge
    wr(12'h000, 32'h7FFF_FFFF, 4'hF);
    rdc("R2 ctrl mask", 12'h000, 1, 32'h110);
    chk("R2 err resp out", {127'd0, err_resp_en}, 128'd1);
    wr(12'h000, 32'h0, 4'b0010);
    rdc("R7 ctrl byte merge", 12'h000, 1, 32'h010);

    // R7 zero extension on enable
    wr(12'h028, 32'hFFFF_FFFF, 4'b1100);
    rdc("R7 en zero extend", 12'h028, 1, 0);
    wr(12'h028, 1, 4'hF);

    // R8 interrupt
    wr(12'h034, 1, 4'hF);
    rdc("R8 set", 12'h020, 1, 1);
    chk("R8 irq on", {127'd0, irq}, 128'd1);
    rdc("R8 set reads 0", 12'h034, 1, 0);
    rdc("R8 clr reads 0", 12'h024, 1, 0);
    wr(12'h024, 32'hFFFF_FFFE, 4'hF);
    rdc("R8 clear bit0 only", 12'h020, 1, 1);
    wr(12'h024, 1, 4'hF);
    rdc("R8 cleared", 12'h020, 1, 0);
    chk("R8 irq off", {127'd0, irq}, 128'd0);
    wr(12'h028, 0, 4'hF);
    wr(12'h034, 1, 4'hF);
    chk("R8 masked irq", {127'd0, irq}, 128'd0);
    wr(12'h028, 1, 4'hF);
    chk("R8 unmasked irq", {127'd0, irq}, 128'd1);
    wr(12'h024, 1, 4'hF);
    fault_event = 1'b1; @(negedge clk); fault_event = 1'b0;
    rdc("R8 fault sets", 12'h020, 1, 1);
    fault_event = 1'b1; wr(12'h024, 1, 4'hF); fault_event = 1'b0;
    rdc("R8 fault beats clear", 12'h020, 1, 1);
    wr(12'h024, 1, 4'hF);

    // R11 unmapped and response valid
    rdc("R11 hole 0x04", 12'h004, 1, 0);
    chk("R11 rsp valid", {127'd0, v}, 128'd1);
    rdc("R11 hole 0x100", 12'h100, 1, 0);
    rdc("R11 hole 0xF00", 12'hF00, 1, 0);
    wr(12'h004, 32'hFFFF_FFFF, 4'hF);
    chk("R11 write no rsp", {127'd0, v}, 128'd0);

    // R3 non-secure isolation
    wr(12'h000, 32'h110, 4'hF);
    for (int o = 0; o <= 12'h34; o += 4) rdc("R3 ns read zero", 12'(o), 0, 0);
    acc(1'b1, 12'h000, 32'hFFFF_FFFF, 4'hF, 1'b0);
    acc(1'b1, 12'h018, 3, 4'hF, 1'b0);
    acc(1'b1, 12'h01C, 0, 4'hF, 1'b0);
    acc(1'b1, 12'h028, 0, 4'hF, 1'b0);
    acc(1'b1, 12'h034, 1, 4'hF, 1'b0);
    rdc("R3 ctrl untouched", 12'h000, 1, 32'h110);
    rdc("R3 ptr untouched", 12'h018, 1, 2);
    rdc("R3 en untouched", 12'h028, 1, 1);
    rdc("R3 stat untouched", 12'h020, 1, 0);
    chk("R3 lut untouched", lut_bits, flat());
    rdc("R3 ptr no ns step", 12'h018, 1, 2);

    // R4 lockdown
    wr(12'h018, 0, 4'hF);
    wr(12'h000, 32'h8000_0110, 4'hF);
    chk("R4 lock out", {127'd0, lock_active}, 128'd1);
    wr(12'h000, 0, 4'hF);
    rdc("R4 ctrl frozen", 12'h000, 1, 32'h8000_0110);
    wr(12'h01C, 32'hCAFE_F00D, 4'hF);
    chk("R4 lut frozen", lut_bits, flat());
    rdc("R4 no step on blocked write", 12'h018, 1, 0);
    wr(12'h028, 0, 4'hF);
    rdc("R4 en frozen", 12'h028, 1, 1);
    wr(12'h034, 1, 4'hF);
    chk("R4 set still works", {127'd0, irq}, 128'd1);
    rdc("R4 read window", 12'h01C, 1, m[0]);
    rdc("R4 read steps", 12'h018, 1, 1);

    // R1 reset ends lockdown
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    for (int k = 0; k < NW; k++) m[k] = '0;
    chk("R1 lock cleared", {127'd0, lock_active}, 128'd0);
    rdc("R1 ctrl again", 12'h000, 1, 32'h100);
    chk("R1 lut cleared", lut_bits, flat());

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule